// File: doc/BRIEF.md
# Sequenced Serial ADC Sweep Controller

This block runs a 16-channel, 12-bit successive-approximation converter attached over a four-wire serial link, and collects one sample from each channel in turn. It derives the serial clock by halving the system clock, frames every transfer with an active-low chip select that spans sixteen serial clock periods, and leaves at least one serial clock of idle time between frames. After reset it issues three dummy frames with the data line held high, so that the converter powers up without any register being written. Only then does it report that it is ready.

A sweep starts with a one-cycle `start` pulse. The two-bit `mode` input is sampled at that moment and picks how channels are sequenced. In manual mode (00) the controller writes the next channel address in every frame. In the two automatic modes (01 and 11) it writes the sequencer once and then lets the converter advance by itself. Because each frame returns the conversion chosen in the frame before it, a sweep takes seventeen frames and the first frame's data is discarded. Each of the sixteen results is presented as a channel index and a 12-bit value with a one-cycle valid strobe. The 4-bit channel tag that the converter returns is compared with the expected channel, and an error flag is raised when they differ. A sweep-done pulse follows the sample for channel 15.

Top module: `adc_sweep_ctrl`

## Requirements
- R1: While chip select is low, `spi_sclk` toggles on every system clock, so it runs at half the system clock rate. Each frame holds chip select low for exactly 32 system clocks and contains exactly 16 rising edges of `spi_sclk`.
- R2: After reset, three frames are sent with `spi_mosi` high for all 16 bits. `ready` stays low until these frames are done, and a `start` pulse during them is ignored.
- R3: Between two frames, chip select stays high for at least two system clocks. `spi_sclk` is high whenever chip select is high.
- R4: `spi_mosi` changes only while `spi_sclk` is low, so it is stable across every rising edge. `spi_miso` is captured on the rising edges.
- R5: The control word is sent MSB first with this layout: bit 15 = 1 (write), bit 14 = mode[1], bits 13:10 = channel address, bits 9:8 = 11, bit 7 = mode[0], bit 6 = 0, bits 5:4 = 11, bits 3:0 = 0.
- R6: In mode 00, a sweep is 17 frames. Frame k (for k from 0 to 15) writes address k, and frame 16 sends all zeros. Mode 10 behaves exactly as mode 00, including zeros in both mode bit positions.
- R7: In modes 01 and 11, frame 0 writes address 15 with the mode bits, and frames 1 to 16 send all zeros.
- R8: Frame k (for k from 1 to 16) yields one sample: `smp_chan` = k-1 and `smp_data` = bits 11:0 of the received word. `smp_valid` is high for exactly one cycle, rising at the edge where chip select rises. Samples therefore come out in channel order 0 to 15.
- R9: `chan_err` is valid together with `smp_valid`. It is 1 exactly when bits 15:12 of the received word differ from `smp_chan`.
- R10: `sweep_done` pulses for one cycle, in the cycle after the channel 15 sample, and at no other time.
- R11: `start` is accepted only while `ready` is high, and `mode` is sampled in that same cycle. A `start` pulse, or a change of `mode`, during a sweep has no effect.
- R12: `ready` is high only when the controller is idle. It goes high the cycle after `sweep_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sweep |
| mode | input | 2 | Sequencing mode, sampled with `start` |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low frame select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| ready | output | 1 | Idle and able to accept `start` |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 4 | Channel index of the sample |
| smp_data | output | 12 | Conversion result |
| chan_err | output | 1 | Returned tag differs from the expected channel |
| sweep_done | output | 1 | Pulse after the last channel of a sweep |

## Verification
A sample for frame k is due at the clock edge that raises chip select, which is 32 system clocks after that frame's chip select fell. `sweep_done` is due one clock after the channel 15 sample, and `ready` one clock after that.

The bench puts the expected control words and samples in queues before it pulses `start`. It compares each captured frame when chip select rises, and each sample in the cycle where `smp_valid` is seen. Outputs are sampled on the falling system clock edge, so each result is read half a cycle after the edge that produced it. The bench also checks that `sweep_done` and `ready` arrive on exactly those following cycles.

// File: rtl/adc_sweep_ctrl.sv
module adc_sweep_ctrl #(
  parameter int NUM_CH       = 16,
  parameter int RES_W        = 12,
  parameter int DUMMY_FRAMES = 3,
  parameter int GAP_SCLK     = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                mode,
  output logic                      spi_sclk,
  output logic                      spi_cs_n,
  output logic                      spi_mosi,
  input  logic                      spi_miso,
  output logic                      ready,
  output logic                      smp_valid,
  output logic [$clog2(NUM_CH)-1:0] smp_chan,
  output logic [RES_W-1:0]          smp_data,
  output logic                      chan_err,
  output logic                      sweep_done
);
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int FRAME_BITS = CH_W + RES_W;
  localparam int ACTIVE     = 2 * FRAME_BITS;
  localparam int LAST       = ACTIVE + 2 * GAP_SCLK - 1;
  localparam int CNT_W      = $clog2(LAST + 1);
  localparam int IDX_MAX    = (NUM_CH + 2 > DUMMY_FRAMES + 1) ? NUM_CH + 2 : DUMMY_FRAMES + 1;
  localparam int IDX_W      = $clog2(IDX_MAX);

  typedef enum logic [1:0] {S_DUMMY, S_IDLE, S_RUN} st_t;

  st_t                   state;
  logic [CNT_W-1:0]      cnt;
  logic [IDX_W-1:0]      fidx;
  logic [1:0]            mode_q;
  logic [FRAME_BITS-1:0] tx_sh, rx_sh;

  function automatic logic [FRAME_BITS-1:0] ctl(input logic [1:0] m, input logic [CH_W-1:0] a);
    return {1'b1, m[1], a, 2'b11, m[0], 1'b0, 2'b11, {(RES_W-8){1'b0}}};
  endfunction

  function automatic logic [FRAME_BITS-1:0] word_for(input logic [1:0] m, input logic [IDX_W-1:0] idx);
    if (!m[0])
      return (idx < IDX_W'(NUM_CH)) ? ctl(m, idx[CH_W-1:0]) : '0;
    return (idx == '0) ? ctl(m, CH_W'(NUM_CH - 1)) : '0;
  endfunction

  wire [1:0]       mode_eff = (mode == 2'b10) ? 2'b00 : mode;
  wire             in_frame = (state != S_IDLE) && (cnt < CNT_W'(ACTIVE));
  wire [IDX_W-1:0] fm1      = fidx - 1'b1;

  assign spi_cs_n = ~in_frame;
  assign spi_sclk = in_frame ? cnt[0] : 1'b1;
  assign spi_mosi = (state == S_RUN && in_frame) ? tx_sh[FRAME_BITS-1] : 1'b1;
  assign ready    = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_DUMMY;
      cnt        <= CNT_W'(ACTIVE);
      fidx       <= '0;
      mode_q     <= 2'b00;
      tx_sh      <= '1;
      rx_sh      <= '0;
      smp_valid  <= 1'b0;
      smp_chan   <= '0;
      smp_data   <= '0;
      chan_err   <= 1'b0;
      sweep_done <= 1'b0;
    end else begin
      smp_valid  <= 1'b0;
      sweep_done <= smp_valid && (smp_chan == CH_W'(NUM_CH - 1));
      if (state == S_IDLE) begin
        if (start) begin
          state  <= S_RUN;
          cnt    <= '0;
          fidx   <= '0;
          mode_q <= mode_eff;
          tx_sh  <= word_for(mode_eff, '0);
        end
      end else begin
        cnt <= (cnt == CNT_W'(LAST)) ? '0 : cnt + 1'b1;
        if (in_frame && cnt[0]) begin
          rx_sh <= {rx_sh[FRAME_BITS-2:0], spi_miso};
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b1};
        end
        if (cnt == CNT_W'(ACTIVE - 1)) begin
          fidx <= fidx + 1'b1;
          if (state == S_RUN && fidx != '0) begin
            smp_valid <= 1'b1;
            smp_chan  <= fm1[CH_W-1:0];
            smp_data  <= {rx_sh[RES_W-2:0], spi_miso};
            chan_err  <= rx_sh[FRAME_BITS-2 -: CH_W] != fm1[CH_W-1:0];
          end
        end
        if (cnt == CNT_W'(LAST)) begin
          if (state == S_DUMMY && fidx == IDX_W'(DUMMY_FRAMES)) begin
            state <= S_IDLE;
            fidx  <= '0;
          end else if (state == S_RUN && fidx == IDX_W'(NUM_CH + 1)) begin
            state <= S_IDLE;
          end else if (state == S_RUN) begin
            tx_sh <= word_for(mode_q, fidx);
          end
        end
      end
    end
  end

  // R3
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R4
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_sclk) && !spi_cs_n) |-> $stable(spi_mosi));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R8
  valid_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $rose(spi_cs_n));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> $past(smp_valid && smp_chan == CH_W'(NUM_CH - 1)));

  // R12
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> ready);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
endmodule

// File: tb/adc_sweep_ctrl_test.sv
module adc_sweep_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [1:0] mode = 2'b00;
  wire sclk, cs_n, mosi, ready, valid, err, done;
  wire [3:0]  chan;
  wire [11:0] data;

  adc_sweep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .ready(ready), .smp_valid(valid), .smp_chan(chan), .smp_data(data),
    .chan_err(err), .sweep_done(done));

  always #5 clk = ~clk;

  typedef struct packed { logic [3:0] ch; logic [11:0] d; logic e; } smp_t;
  smp_t        exp_q[$];
  logic [15:0] word_q[$];
  int tests = 0, fails = 0, cycles = 0, done_cnt = 0, frames = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] val(input int ch, input int s);
    return 12'((ch * 211 + s * 97 + 13) % 4096);
  endfunction

  function automatic logic [15:0] cw(input logic [1:0] m, input logic [3:0] a);
    return {1'b1, m[1], a, 2'b11, m[0], 1'b0, 2'b11, 4'b0000};
  endfunction

  // converter model
  int pwr = 0, k = 0, nrise = 0, sw = 0, fault_ch = -1;
  bit in_fr = 0, auto_m = 0;
  logic [15:0] rx = '0, txw = '0;
  logic [3:0]  cur = '0, nxt;

  always @(negedge cs_n) if (rst_n) in_fr = 1;
  always @(posedge sclk) if (in_fr && !cs_n) begin rx = {rx[14:0], mosi}; nrise++; end
  always @(negedge sclk) begin
    #1;
    if (in_fr && !cs_n && k < 16) begin miso = txw[15-k]; k++; end
  end
  always @(posedge cs_n) if (in_fr) begin
    in_fr = 0;
    check(nrise == 16, "R1 rising edges per frame", nrise, 16);
    if (word_q.size() == 0) check(0, "R6 R7 unexpected frame", int'(rx), 0);
    else begin
      logic [15:0] w;
      w = word_q.pop_front();
      check(rx == w, frames < 3 ? "R2 dummy frame word" : "R5 R6 R7 control word", int'(rx), int'(w));
    end
    frames++;
    if (pwr < 3) pwr++;
    else begin
      nxt = cur;
      if (rx[15]) begin auto_m = rx[14] | rx[7]; nxt = auto_m ? 4'd0 : rx[13:10]; end
      else if (auto_m) nxt = cur + 4'd1;
      cur = nxt;
    end
    txw = {cur ^ ((int'(cur) == fault_ch) ? 4'd1 : 4'd0), val(int'(cur), sw)};
    k = 0; nrise = 0; rx = '0;
  end

  // monitor
  bit prev15 = 0, chk_ready = 0, prev_cs = 1;
  int hi = 0;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n) begin
      if (chk_ready) begin check(ready == 1'b1, "R12 ready after done", ready, 1); chk_ready = 0; end
      if (prev15) check(done == 1'b1, "R10 done after ch15", done, 1);
      else if (done) check(0, "R10 stray done", done, 0);
      if (done) begin done_cnt++; chk_ready = 1; end
      if (valid) begin
        if (exp_q.size() == 0) check(0, "R8 unexpected sample", chan, 0);
        else begin
          smp_t e;
          e = exp_q.pop_front();
          check(chan == e.ch, "R8 channel", chan, e.ch);
          check(data == e.d, "R8 data", data, e.d);
          check(err == e.e, "R9 tag error flag", err, e.e);
        end
      end
      prev15 = valid && chan == 4'd15;
      if (!cs_n && prev_cs) check(hi >= 2, "R3 chip select gap", hi, 2);
      hi = cs_n ? hi + 1 : 0;
      prev_cs = cs_n;
    end
  end

  // driver
  task automatic run_sweep(input logic [1:0] m, input int fch, input bit poke);
    logic [1:0] me;
    int d0;
    while (!ready) @(negedge clk);
    me = (m == 2'b10) ? 2'b00 : m;
    for (int f = 0; f < 17; f++) begin
      if (!me[0]) word_q.push_back(f < 16 ? cw(me, 4'(f)) : 16'h0000);
      else        word_q.push_back(f == 0 ? cw(me, 4'd15) : 16'h0000);
    end
    sw++;
    fault_ch = fch;
    for (int c = 0; c < 16; c++) exp_q.push_back({4'(c), val(c, sw), c == fch});
    d0 = done_cnt;
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0; mode = ~m;
    check(ready == 1'b0, "R11 start accepted", ready, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; mode = m ^ 2'b01;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all samples seen", exp_q.size(), 0);
    check(word_q.size() == 0, "R6 R7 frame count", word_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) word_q.push_back(16'hFFFF);
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R2 reset ready", ready, 0);
    check(cs_n == 1'b1, "R3 reset chip select", cs_n, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(ready == 1'b0, "R2 ready during dummy", ready, 0);
    start = 1'b1; mode = 2'b01;
    @(negedge clk);
    start = 1'b0;
    run_sweep(2'b00, -1, 0);
    run_sweep(2'b01, 5, 1);
    run_sweep(2'b11, -1, 0);
    run_sweep(2'b10, 0, 1);
    run_sweep(2'b00, 15, 0);
    check(frames == 3 + 5 * 17, "R2 R6 R7 total frames", frames, 3 + 5 * 17);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule